// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Engine

This block is one DMA channel that runs a single transfer descriptor at a time. A descriptor has three parts: a 32-bit control word, a source address and a destination address. The host writes the active descriptor through a load port. The same port can also fill a shadow descriptor, which the channel takes over when the active descriptor finishes. Once the descriptor is valid and the channel trigger is set, the channel moves data one beat at a time. Each beat reads one item from the source and then writes that item to the destination, with a ready handshake on each side.

The remaining beat count is stored in the control word as a value minus one. The channel counts it down in place, so the control word read back on `cfg_status` always shows the beats still to be done. After each beat, each address moves by a stride of zero, one, two or four data widths. When the count runs out, the channel can raise either or both of two sticky interrupt flags, and it can drop its trigger. It then either chains to the shadow descriptor or goes idle. A `done` pulse marks the end of each descriptor.

Top module: `dma_desc_chan`

## Requirements
- R1: After reset every output is 0, including the 32-bit `cfg_status` word, `busy`, `done`, `err` and both interrupt flags.
- R2: The channel starts no beat while control bit 0 (valid) is 0. A `set_valid` pulse sets that bit on an idle channel, and a pending trigger then starts the descriptor.
- R3: The channel trigger is set in two ways: by a `trig_in` pulse, or by loading an active or shadow word with bit 2 at 1. A valid descriptor with no trigger stays idle.
- R4: Bits 25:16 hold the beat count minus one, so a value of N performs N+1 beats. While beats are running, that field on `cfg_status` shows the remaining count: N at the first beat, N-1 at the second, and so on.
- R5: Bits 9:8 select the width. Code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. The code appears on `rd_size` and `wr_size`, and the data read in a beat is written unchanged in the same beat.
- R6: Bits 13:12 set the source stride and bits 15:14 set the destination stride. Code 0 keeps the address fixed. Codes 1, 2 and 3 add 1, 2 and 4 widths in bytes after each beat.
- R7: Each beat holds `rd_req` until `rd_ready`, and only then raises `wr_req`. It holds `wr_req` until `wr_ready`. `rd_req` and `wr_req` are never high together.
- R8: When the count runs out with bit 1 (reload) at 1, the shadow descriptor becomes active. With reload at 0, the valid bit clears and the channel idles.
- R9: If bit 3 is 1, the trigger drops when the descriptor runs out, and a reloaded descriptor waits for a new trigger. If bit 3 is 0, the trigger stays set and a reloaded valid descriptor starts at once.
- R10: Bit 4 sets `int_a` and bit 5 sets `int_b` when the descriptor runs out. Both flags stay high until the matching bit of `int_clr` is pulsed (bit 0 for A, bit 1 for B).
- R11: Launching with width code 3 moves no data. It sets `err`, clears the valid bit and leaves the channel idle. Loading a new active descriptor clears `err`.
- R12: `done` is high for exactly one cycle per finished descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load strobe for a descriptor |
| ld_shadow | input | 1 | 1 loads the shadow descriptor; 0 loads the active one (accepted only while idle) |
| ld_cfg | input | 32 | Control word to load |
| ld_src | input | AW | Source address to load |
| ld_dst | input | AW | Destination address to load |
| set_valid | input | 1 | Marks the idle active descriptor valid |
| trig_in | input | 1 | Trigger pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read width code |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_data | input | DW | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write width code |
| wr_data | output | DW | Write data |
| wr_ready | input | 1 | Write accepted |
| int_clr | input | 2 | Write-one-to-clear for int_b (bit 1) and int_a (bit 0) |
| int_a | output | 1 | Sticky interrupt flag A |
| int_b | output | 1 | Sticky interrupt flag B |
| err | output | 1 | Reserved width code seen at launch |
| done | output | 1 | One-cycle end-of-descriptor pulse |
| busy | output | 1 | Beat in progress |
| cfg_status | output | 32 | Live active control word, including the remaining count |

## Verification
The bench targets these corner cases:
- Count 0 must give exactly one beat. An off-by-one design would move a second beat, or none.
- Stride code 3 must scale by width. A design that ignored the width would step by 4 bytes, not 16.
- Stalls on `rd_ready` and `wr_ready` must hold the requests steady. A design that overlapped the phases would issue a write before its read returned.
- Two reload chains are run, one keeping the trigger and one dropping it. A wrong design would start the second descriptor early, or leave it stuck.
- A reserved width must not start a transfer. A design that tolerated it would move data.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } chan_state_e;

  // control word bit positions
  localparam int unsigned BIT_VALID  = 0;
  localparam int unsigned BIT_RELOAD = 1;
  localparam int unsigned BIT_SWTRIG = 2;
  localparam int unsigned BIT_CLRTRG = 3;
  localparam int unsigned BIT_INTA   = 4;
  localparam int unsigned BIT_INTB   = 5;
  localparam int unsigned WID_LO     = 8;
  localparam int unsigned SINC_LO    = 12;
  localparam int unsigned DINC_LO    = 14;
  localparam int unsigned CNT_LO     = 16;
  localparam int unsigned CNT_W      = 10;
  localparam int unsigned STEP_W     = 6;

  // byte stride: 0 for code 0, otherwise width bytes times 1, 2 or 4
  function automatic logic [STEP_W-1:0] stride_bytes(input logic [1:0] wcode,
                                                     input logic [1:0] inc);
    int sh;
    if (inc == 2'd0) return '0;
    sh = int'(wcode) + int'(inc) - 1;
    return STEP_W'(1) << sh;
  endfunction

endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int unsigned AW = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load,
  input  logic [AW-1:0]                       load_val,
  input  logic                                adv,
  input  logic [dma_desc_pkg::STEP_W-1:0]     step,
  output logic [AW-1:0]                       addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= addr + AW'(step);
  end

  // R6: the pointer moves only on a load or a finished beat
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(addr));

endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          last,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_ready,
  output logic          rd_req,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  output logic          beat_done,
  output logic          desc_end,
  output logic          busy
);
  import dma_desc_pkg::*;

  chan_state_e   state_q, state_d;
  logic [DW-1:0] hold_q;

  assign rd_req    = (state_q == ST_READ);
  assign wr_req    = (state_q == ST_WRITE);
  assign busy      = (state_q != ST_IDLE);
  assign beat_done = wr_req && wr_ready;
  assign desc_end  = beat_done && last;
  assign wr_data   = hold_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  if (rd_ready) state_d = ST_WRITE;
      ST_WRITE: if (wr_ready) state_d = last ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rd_req && rd_ready) hold_q <= rd_data;
    end
  end

  // R7: read and write phases never overlap
  assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // R7: a write phase opens only after an accepted read
  assert_wr_after_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_req && rd_ready));

  // R7: a stalled read keeps requesting
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> rd_req);

endmodule

// File: rtl/dma_desc_chan.sv
module dma_desc_chan #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic          ld_shadow,
  input  logic [31:0]   ld_cfg,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic          set_valid,
  input  logic          trig_in,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  input  logic [1:0]    int_clr,
  output logic          int_a,
  output logic          int_b,
  output logic          err,
  output logic          done,
  output logic          busy,
  output logic [31:0]   cfg_status
);
  import dma_desc_pkg::*;

  localparam int unsigned NPTR = 2;

  logic [31:0]      cfg_q, shd_cfg_q;
  logic [AW-1:0]    shd_src_q, shd_dst_q;
  logic             trig_q, int_a_q, int_b_q, err_q, done_q;
  logic [1:0]       wcode;
  logic [CNT_W-1:0] cnt;
  logic             idle, load_act, launch, bad_launch, beat_done, desc_end, last_beat;
  logic             chain;

  assign wcode     = cfg_q[WID_LO +: 2];
  assign cnt       = cfg_q[CNT_LO +: CNT_W];
  assign idle      = !busy;
  assign load_act  = ld_valid && !ld_shadow && idle;
  assign launch    = idle && cfg_q[BIT_VALID] && trig_q && (wcode != 2'd3);
  assign bad_launch= idle && cfg_q[BIT_VALID] && trig_q && (wcode == 2'd3);
  assign last_beat = (cnt == '0);
  assign chain     = desc_end && cfg_q[BIT_RELOAD];

  // source and destination pointers share one structure
  logic [AW-1:0]     ptr_addr [NPTR];
  logic [AW-1:0]     ptr_init [NPTR];
  logic [AW-1:0]     ptr_next [NPTR];
  logic [1:0]        ptr_inc  [NPTR];

  assign ptr_init[0] = ld_src;
  assign ptr_init[1] = ld_dst;
  assign ptr_next[0] = shd_src_q;
  assign ptr_next[1] = shd_dst_q;
  assign ptr_inc[0]  = cfg_q[SINC_LO +: 2];
  assign ptr_inc[1]  = cfg_q[DINC_LO +: 2];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_ptr #(.AW(AW)) ptr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_act || chain),
      .load_val (load_act ? ptr_init[g] : ptr_next[g]),
      .adv      (beat_done),
      .step     (stride_bytes(wcode, ptr_inc[g])),
      .addr     (ptr_addr[g])
    );
  end

  dma_beat_seq #(.DW(DW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (launch),
    .last      (last_beat),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .wr_ready  (wr_ready),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .wr_data   (wr_data),
    .beat_done (beat_done),
    .desc_end  (desc_end),
    .busy      (busy)
  );

  // active control word: load, validate, count down, chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load_act) begin
      cfg_q <= ld_cfg;
    end else if (set_valid && idle) begin
      cfg_q[BIT_VALID] <= 1'b1;
    end else if (bad_launch) begin
      cfg_q[BIT_VALID] <= 1'b0;
    end else if (desc_end) begin
      if (cfg_q[BIT_RELOAD]) cfg_q <= shd_cfg_q;
      else                   cfg_q[BIT_VALID] <= 1'b0;
    end else if (beat_done) begin
      cfg_q[CNT_LO +: CNT_W] <= cnt - CNT_W'(1);
    end
  end

  // shadow descriptor for chaining
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_cfg_q <= '0;
      shd_src_q <= '0;
      shd_dst_q <= '0;
    end else if (ld_valid && ld_shadow) begin
      shd_cfg_q <= ld_cfg;
      shd_src_q <= ld_src;
      shd_dst_q <= ld_dst;
    end
  end

  // trigger, flags and done pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      int_a_q <= 1'b0;
      int_b_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      trig_q <= ((trig_q && !(desc_end && cfg_q[BIT_CLRTRG]) && !bad_launch)
                || trig_in
                || (load_act && ld_cfg[BIT_SWTRIG])
                || (chain && shd_cfg_q[BIT_SWTRIG]));
      int_a_q <= (int_a_q && !int_clr[0]) || (desc_end && cfg_q[BIT_INTA]);
      int_b_q <= (int_b_q && !int_clr[1]) || (desc_end && cfg_q[BIT_INTB]);
      err_q   <= (err_q && !load_act) || bad_launch;
      done_q  <= desc_end;
    end
  end

  assign rd_addr    = ptr_addr[0];
  assign wr_addr    = ptr_addr[1];
  assign rd_size    = wcode;
  assign wr_size    = wcode;
  assign int_a      = int_a_q;
  assign int_b      = int_b_q;
  assign err        = err_q;
  assign done       = done_q;
  assign cfg_status = cfg_q;

  // R2: an idle channel with an invalid descriptor stays idle
  assert_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_status[BIT_VALID]) |=> !busy);

  // R4: every non-final beat lowers the stored count by one
  assert_count_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !desc_end) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R10: interrupt flag A holds until cleared
  assert_int_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_a && !int_clr[0]) |=> int_a);

  // R11: reserved width moves nothing and flags an error
  assert_bad_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_launch |=> (!busy && err));

  // R12: done never lasts two cycles
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/dma_desc_chan_tb.sv
module dma_desc_chan_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] MASK = 32'hA5A5_0000;

  typedef struct packed {
    logic [1:0]  w;
    logic [1:0]  si;
    logic [1:0]  di;
    logic [9:0]  n;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] src_last;
    logic [31:0] dst_last;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 2'd1, 2'd0, 10'd3, 32'h100,  32'h200,  32'h103,  32'h200},
    '{2'd1, 2'd2, 2'd1, 10'd2, 32'h1000, 32'h2000, 32'h1008, 32'h2004},
    '{2'd2, 2'd3, 2'd3, 10'd1, 32'h40,   32'h80,   32'h50,   32'h90},
    '{2'd2, 2'd0, 2'd2, 10'd0, 32'h300,  32'h400,  32'h300,  32'h400}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, ld_shadow = 0, set_valid = 0, trig_in = 0;
  logic [31:0] ld_cfg = '0, ld_src = '0, ld_dst = '0;
  logic [1:0] int_clr = '0;
  logic rd_en = 1, wr_en = 1;
  logic rd_req, rd_ready, wr_req, wr_ready, int_a, int_b, err, done, busy;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data, cfg_status;
  logic [1:0] rd_size, wr_size;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, done_wide = 0;
  logic prev_done = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
  logic [1:0] last_rd_size = '0;
  logic [9:0] cnt_log [256];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_ready = rd_req && rd_en;
  assign wr_ready = wr_req && wr_en;
  assign rd_data  = rd_addr ^ MASK;

  dma_desc_chan dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_shadow(ld_shadow),
    .ld_cfg(ld_cfg), .ld_src(ld_src), .ld_dst(ld_dst), .set_valid(set_valid),
    .trig_in(trig_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .wr_ready(wr_ready), .int_clr(int_clr),
    .int_a(int_a), .int_b(int_b), .err(err), .done(done), .busy(busy),
    .cfg_status(cfg_status)
  );

  // observe handshakes just before the edge that completes them
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req && rd_ready) begin
        rd_cnt = rd_cnt + 1;
        last_rd_addr = rd_addr;
        last_rd_size = rd_size;
      end
      if (wr_req && wr_ready) begin
        if (wr_cnt < 256) cnt_log[wr_cnt] = cfg_status[25:16];
        wr_cnt = wr_cnt + 1;
        last_wr_addr = wr_addr;
        last_wr_data = wr_data;
      end
      if (done) done_cnt = done_cnt + 1;
      if (done && prev_done) done_wide = done_wide + 1;
      prev_done = done;
    end
  end

  function automatic logic [31:0] mk(bit v, bit r, bit s, bit c, bit ia, bit ib,
                                     logic [1:0] w, logic [1:0] si,
                                     logic [1:0] di, logic [9:0] n);
    logic [31:0] x = '0;
    x[0] = v; x[1] = r; x[2] = s; x[3] = c; x[4] = ia; x[5] = ib;
    x[9:8] = w; x[13:12] = si; x[15:14] = di; x[25:16] = n;
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit shadow, input logic [31:0] c,
                      input logic [31:0] s, input logic [31:0] d);
    ld_valid = 1; ld_shadow = shadow; ld_cfg = c; ld_src = s; ld_dst = d;
    tick();
    ld_valid = 0; ld_shadow = 0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 3000; i++) begin
      if (done_cnt >= target) break;
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int b0, d0, r0;
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    chk({busy, done, err, int_a, int_b, rd_req, wr_req} == 7'b0, "R1 outputs",
        {busy, done, err, int_a, int_b, rd_req, wr_req}, 0);
    chk(cfg_status == 32'h0, "R1 cfg_status", cfg_status, 0);

    // table of descriptors, one loop
    for (int k = 0; k < 4; k++) begin
      b0 = wr_cnt; d0 = done_cnt;
      load(0, mk(1,0,1,1,1,0, VECS[k].w, VECS[k].si, VECS[k].di, VECS[k].n),
           VECS[k].src, VECS[k].dst);
      wait_done(d0 + 1);
      tick();
      chk(wr_cnt - b0 == int'(VECS[k].n) + 1, "R4 beat count", wr_cnt - b0,
          int'(VECS[k].n) + 1);
      if (VECS[k].n > 0)
        chk(cnt_log[b0+1] == VECS[k].n - 10'd1, "R4 remaining count",
            cnt_log[b0+1], VECS[k].n - 10'd1);
      chk(last_rd_addr == VECS[k].src_last, "R6 source stride", last_rd_addr,
          VECS[k].src_last);
      chk(last_wr_addr == VECS[k].dst_last, "R6 destination stride",
          last_wr_addr, VECS[k].dst_last);
      chk(last_wr_data == (VECS[k].src_last ^ MASK), "R5 data passes",
          last_wr_data, VECS[k].src_last ^ MASK);
      chk(last_rd_size == VECS[k].w, "R5 size code", last_rd_size, VECS[k].w);
      chk(int_a == 1'b1, "R10 int_a raised", int_a, 1);
      chk(!busy && !cfg_status[0], "R8 no reload idles", cfg_status[0], 0);
      int_clr = 2'b01; tick(); int_clr = 2'b00;
    end

    // R2: invalid descriptor stays inert until set_valid
    b0 = wr_cnt; d0 = done_cnt;
    load(0, mk(0,0,1,1,0,0, 2'd0, 2'd1, 2'd1, 10'd1), 32'h10, 32'h20);
    tick(8);
    chk(!busy && wr_cnt == b0, "R2 inert while invalid", wr_cnt - b0, 0);
    set_valid = 1; tick(); set_valid = 0;
    wait_done(d0 + 1);
    chk(wr_cnt - b0 == 2, "R2 runs after set_valid", wr_cnt - b0, 2);

    // R3: valid but untriggered waits for trig_in
    b0 = wr_cnt; d0 = done_cnt;
    load(0, mk(1,0,0,1,0,0, 2'd0, 2'd0, 2'd0, 10'd0), 32'h30, 32'h40);
    tick(8);
    chk(!busy && wr_cnt == b0, "R3 waits for trigger", wr_cnt - b0, 0);
    trig_in = 1; tick(); trig_in = 0;
    wait_done(d0 + 1);
    chk(wr_cnt - b0 == 1, "R3 trig_in starts", wr_cnt - b0, 1);

    // R7: read and write stalls
    b0 = wr_cnt; d0 = done_cnt;
    rd_en = 0;
    load(0, mk(1,0,1,1,0,0, 2'd2, 2'd0, 2'd0, 10'd0), 32'h500, 32'h600);
    tick(6);
    chk(rd_req && !wr_req && rd_addr == 32'h500, "R7 read held", rd_addr, 32'h500);
    rd_en = 1; wr_en = 0;
    tick(2);
    chk(wr_req && !rd_req && wr_addr == 32'h600, "R7 write after read",
        wr_addr, 32'h600);
    tick(4);
    chk(wr_req && wr_cnt == b0, "R7 write held", wr_cnt - b0, 0);
    wr_en = 1;
    wait_done(d0 + 1);
    chk(wr_cnt - b0 == 1 && last_wr_data == (32'h500 ^ MASK), "R7 beat completes",
        last_wr_data, 32'h500 ^ MASK);

    // R8/R9: chain keeping the trigger
    b0 = wr_cnt; d0 = done_cnt;
    load(1, mk(1,0,0,1,0,1, 2'd0, 2'd1, 2'd1, 10'd1), 32'h700, 32'h800);
    load(0, mk(1,1,1,0,0,0, 2'd0, 2'd1, 2'd1, 10'd0), 32'h10, 32'h20);
    wait_done(d0 + 2);
    tick();
    chk(done_cnt - d0 == 2 && wr_cnt - b0 == 3, "R8 chained beats", wr_cnt - b0, 3);
    chk(last_wr_addr == 32'h801, "R8 shadow addresses", last_wr_addr, 32'h801);
    chk(int_b == 1'b1, "R10 int_b raised", int_b, 1);
    chk(!cfg_status[0], "R8 chain ends idle", cfg_status[0], 0);

    // R9: chain dropping the trigger
    b0 = wr_cnt; d0 = done_cnt;
    load(1, mk(1,0,0,1,1,0, 2'd0, 2'd0, 2'd0, 10'd0), 32'h900, 32'h900);
    load(0, mk(1,1,1,1,0,0, 2'd0, 2'd0, 2'd0, 10'd0), 32'hA00, 32'hA00);
    wait_done(d0 + 1);
    tick(8);
    chk(done_cnt - d0 == 1 && !busy && cfg_status[0], "R9 reloaded waits",
        done_cnt - d0, 1);
    trig_in = 1; tick(); trig_in = 0;
    wait_done(d0 + 2);
    chk(done_cnt - d0 == 2 && last_wr_addr == 32'h900, "R9 resumes on trigger",
        last_wr_addr, 32'h900);

    // R10: sticky flags, separate clears
    tick(5);
    chk(int_a && int_b, "R10 both sticky", {int_a, int_b}, 2'b11);
    int_clr = 2'b01; tick(); int_clr = 2'b00;
    chk(!int_a && int_b, "R10 clear A only", {int_a, int_b}, 2'b01);
    int_clr = 2'b10; tick(); int_clr = 2'b00;
    chk(!int_b, "R10 clear B", int_b, 0);

    // R11: reserved width
    b0 = wr_cnt; r0 = rd_cnt;
    load(0, mk(1,0,1,1,1,0, 2'd3, 2'd1, 2'd1, 10'd2), 32'hB00, 32'hC00);
    tick(5);
    chk(err && !busy && wr_cnt == b0 && rd_cnt == r0, "R11 no transfer", err, 1);
    chk(!cfg_status[0] && !int_a, "R11 valid cleared", cfg_status[0], 0);
    load(0, mk(0,0,0,0,0,0, 2'd0, 2'd0, 2'd0, 10'd0), 32'h0, 32'h0);
    chk(!err, "R11 err cleared by load", err, 0);

    // R12: done pulses never stretched
    chk(done_wide == 0, "R12 single-cycle done", done_wide, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule